// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block sits between a UART deserializer and the register read port of the receiver. It keeps up to four received bytes and hands them out oldest first. Each read strobe pops one byte, and the byte is registered so that it is stable in the cycle after the strobe. The block raises a ready flag while anything is stored and a full flag while all four slots are occupied. It stops the deserializer through `in_ready` whenever the receiver is disabled or no slot is free.

A line break detected by the deserializer is stored as a zero byte. A break is taken even when the receiver is disabled. When the queue is full, a break is not dropped: it replaces the newest stored byte. Every break also sets a sticky delta-break flag, which stays set until an external clear pulse. A receiver reset pulse discards the queue contents.

Top module: `uart_rxq_top`

## Requirements
- R1: After `rst`, `rdy_flag`, `full_flag` and `brk_flag` are 0, `rd_data` is 0x00 and the queue is empty.
- R2: Bytes are returned in arrival order. A read strobe with a non-empty queue loads the oldest byte into `rd_data` at that clock edge. `rd_data` holds its value in every cycle with no read strobe.
- R3: `rdy_flag` is 1 exactly when at least one byte is stored.
- R4: `full_flag` is 1 exactly when four bytes are stored. Any read that pops a byte clears it, unless a break is stored in the same cycle.
- R5: `in_ready` = `rx_en` AND not full AND not `brk_evt`. A byte on `in_data` is stored only in a cycle where `in_valid` and `in_ready` are both 1. Otherwise it is ignored.
- R6: A read strobe while the queue is empty sets `rd_data` to 0x00 and leaves the count and flags unchanged.
- R7: `brk_evt` stores 0x00 whatever the value of `rx_en`. If the queue is full and no byte is popped in that cycle, the 0x00 overwrites the newest entry and the count stays at four.
- R8: `brk_evt` sets `brk_flag` on the next edge. The flag then stays 1 until a cycle with `brk_clr` and no `brk_evt`. If both arrive in the same cycle, the set wins.
- R9: `rx_reset` empties the queue and clears `rdy_flag` and `full_flag`. It overrides a push or a read in the same cycle, and in that cycle `rd_data` keeps its value. It does not affect `brk_flag`.
- R10: A read and a push in the same cycle are both performed, and the count and flags show the net result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable for normal bytes |
| in_valid | input | 1 | Deserializer offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Queue accepts a normal byte this cycle |
| brk_evt | input | 1 | Break detected; store 0x00 |
| rd_stb | input | 1 | Register read of the receive byte |
| rd_data | output | 8 | Registered read result |
| rx_reset | input | 1 | Receiver reset pulse |
| brk_clr | input | 1 | Clears the delta-break flag |
| rdy_flag | output | 1 | At least one byte is stored |
| full_flag | output | 1 | Four bytes are stored |
| brk_flag | output | 1 | Sticky delta-break flag |

## Verification
The operations that collide are a read pop and a store in the same cycle. The store may be a normal byte or a break. The case that matters most is a break arriving on a full queue together with a read: the read frees the head slot, so the break must be appended and must not overwrite the newest byte. Directed steps provoke both the overwrite path and the pop-plus-append path, and a long random run mixes reads, pushes and breaks at every fill level. Each cycle the bench compares the registered read value, both flags and `in_ready` against a reference queue it updates from the requirements.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;
    parameter int unsigned RXQ_DATA_W = 8;
    parameter int unsigned RXQ_DEPTH  = 4;

    typedef logic [RXQ_DATA_W-1:0] rxq_byte_t;

    localparam rxq_byte_t BREAK_BYTE = '0;

    // One store request into the queue.
    typedef struct packed {
        logic      valid;
        logic      overwrite;  // replace newest entry instead of appending
        rxq_byte_t data;
    } rxq_push_t;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_POP   = 2'd1,
        RD_EMPTY = 2'd2
    } rxq_rd_kind_t;

    function automatic rxq_push_t make_push(input logic v, input logic ow,
                                            input rxq_byte_t d);
        rxq_push_t p;
        p.valid     = v;
        p.overwrite = ow;
        p.data      = d;
        return p;
    endfunction
endpackage

// File: rtl/rxq_admit.sv
`timescale 1ns/1ps
module rxq_admit
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             rx_en,
    input  logic             in_valid,
    input  rxq_byte_t        in_data,
    input  logic             brk_evt,
    input  logic             rd_stb,
    input  logic             rx_reset,
    output logic             in_ready,
    output rxq_push_t        push,
    output rxq_rd_kind_t     rd_kind
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic full_now;
    logic empty_now;

    assign full_now  = (cnt == CNT_FULL);
    assign empty_now = (cnt == '0);

    // Normal bytes wait while a break owns the store path.
    assign in_ready = rx_en & ~full_now & ~brk_evt;

    always_comb begin
        if (rx_reset)
            rd_kind = RD_NONE;
        else if (rd_stb)
            rd_kind = empty_now ? RD_EMPTY : RD_POP;
        else
            rd_kind = RD_NONE;
    end

    always_comb begin
        if (rx_reset)
            push = make_push(1'b0, 1'b0, BREAK_BYTE);
        else if (brk_evt)
            // A pop in the same cycle frees a slot, so append instead.
            push = make_push(1'b1, full_now & (rd_kind != RD_POP), BREAK_BYTE);
        else if (in_valid & in_ready)
            push = make_push(1'b1, 1'b0, in_data);
        else
            push = make_push(1'b0, 1'b0, in_data);
    end
endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1),
    parameter int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  rxq_push_t        push,
    input  rxq_rd_kind_t     rd_kind,
    output logic [CNT_W-1:0] cnt,
    output rxq_byte_t        rd_data
);
    localparam int unsigned SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    rxq_byte_t        mem [DEPTH];
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] wr_idx;
    logic [SUM_W-1:0] tail_sum;
    logic [DEPTH-1:0] wr_hit;
    logic             pop;
    logic             grow;

    assign pop  = (rd_kind == RD_POP);
    assign grow = push.valid & ~push.overwrite;

    // The tail slot does not move on a pop: the freed head slot lies behind it.
    assign tail_sum = SUM_W'(head) + SUM_W'(cnt);

    always_comb begin
        if (push.overwrite)
            wr_idx = (head == '0) ? LAST_P : head - PTR_W'(1);
        else if (tail_sum >= DEPTH_S)
            wr_idx = PTR_W'(tail_sum - DEPTH_S);
        else
            wr_idx = PTR_W'(tail_sum);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign wr_hit[i] = push.valid & (wr_idx == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_hit[i])
                mem[i] <= push.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (pop)
                head <= (head == LAST_P) ? '0 : head + PTR_W'(1);
            cnt <= cnt + CNT_W'(grow) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_kind == RD_POP)
            rd_data <= mem[head];
        else if (rd_kind == RD_EMPTY)
            rd_data <= '0;
    end
endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             brk_evt,
    input  logic             brk_clr,
    output logic             rdy_flag,
    output logic             full_flag,
    output logic             brk_flag
);
    assign rdy_flag  = (cnt != '0);
    assign full_flag = (cnt == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst)
            brk_flag <= 1'b0;
        else if (brk_evt)
            brk_flag <= 1'b1;
        else if (brk_clr)
            brk_flag <= 1'b0;
    end
endmodule

// File: rtl/uart_rxq_top.sv
`timescale 1ns/1ps
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_en,
    input  logic                  in_valid,
    input  logic [RXQ_DATA_W-1:0] in_data,
    output logic                  in_ready,
    input  logic                  brk_evt,
    input  logic                  rd_stb,
    output logic [RXQ_DATA_W-1:0] rd_data,
    input  logic                  rx_reset,
    input  logic                  brk_clr,
    output logic                  rdy_flag,
    output logic                  full_flag,
    output logic                  brk_flag
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt;
    rxq_push_t        push;
    rxq_rd_kind_t     rd_kind;

    rxq_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) admit_i (
        .cnt      (cnt),
        .rx_en    (rx_en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .brk_evt  (brk_evt),
        .rd_stb   (rd_stb),
        .rx_reset (rx_reset),
        .in_ready (in_ready),
        .push     (push),
        .rd_kind  (rd_kind)
    );

    rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (rx_reset),
        .push    (push),
        .rd_kind (rd_kind),
        .cnt     (cnt),
        .rd_data (rd_data)
    );

    rxq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) status_i (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt),
        .brk_evt   (brk_evt),
        .brk_clr   (brk_clr),
        .rdy_flag  (rdy_flag),
        .full_flag (full_flag),
        .brk_flag  (brk_flag)
    );
endmodule

// File: rtl/uart_rxq_checker.sv
`timescale 1ns/1ps
module uart_rxq_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       in_ready,
    input logic       brk_evt,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       rx_reset,
    input logic       brk_clr,
    input logic       rdy_flag,
    input logic       full_flag,
    input logic       brk_flag
);
    a_r4_full_has_data: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> rdy_flag);

    a_r5_blocked_when_full: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> !in_ready);

    a_r5_ready_needs_enable: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (rx_en && !brk_evt));

    a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !rdy_flag && !rx_reset) |=> (rd_data == 8'h00));

    a_r7_break_stored: assert property (@(posedge clk) disable iff (rst)
        (brk_evt && !rx_reset) |=> rdy_flag);

    a_r8_break_sets: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> brk_flag);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (brk_flag && !brk_clr) |=> brk_flag);

    a_r9_reset_empties: assert property (@(posedge clk) disable iff (rst)
        rx_reset |=> (!rdy_flag && !full_flag));
endmodule

bind uart_rxq_top uart_rxq_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .in_ready  (in_ready),
    .brk_evt   (brk_evt),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .rx_reset  (rx_reset),
    .brk_clr   (brk_clr),
    .rdy_flag  (rdy_flag),
    .full_flag (full_flag),
    .brk_flag  (brk_flag)
);

// File: tb/uart_rxq_top_tb_top.sv
`timescale 1ns/1ps
module uart_rxq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, in_valid = 1'b0, brk_evt = 1'b0, rd_stb = 1'b0;
    logic       rx_reset = 1'b0, brk_clr = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, rdy_flag, full_flag, brk_flag;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Reference queue
    logic [7:0] mq [4];
    int         mcnt  = 0;
    logic [7:0] m_rd  = 8'h00;
    bit         m_brk = 0;

    always #10 clk = ~clk;  // 50 MHz

    uart_rxq_top dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .brk_evt(brk_evt),
        .rd_stb(rd_stb), .rd_data(rd_data), .rx_reset(rx_reset),
        .brk_clr(brk_clr), .rdy_flag(rdy_flag), .full_flag(full_flag),
        .brk_flag(brk_flag)
    );

    task automatic chk(input string req, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%02h expected=%02h", req, tag, act, exp);
        end
    endtask

    function automatic bit exp_ready(input bit e, input bit b);
        return e && (mcnt < 4) && !b;
    endfunction

    task automatic model_edge(input bit v, input logic [7:0] d, input bit b,
                              input bit r, input bit rr, input bit e, input bit c);
        bit acc;
        acc = exp_ready(e, b);
        if (rr) begin
            mcnt = 0;                                  // R9
        end else begin
            if (r) begin
                if (mcnt > 0) begin
                    m_rd = mq[0];
                    for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
                    mcnt--;
                end else begin
                    m_rd = 8'h00;                      // R6
                end
            end
            if (b) begin
                if (mcnt == 4) mq[3] = 8'h00;          // R7 overwrite
                else begin mq[mcnt] = 8'h00; mcnt++; end
            end else if (v && acc) begin
                mq[mcnt] = d; mcnt++;
            end
        end
        if (b) m_brk = 1;
        else if (c) m_brk = 0;
    endtask

    // One cycle: drive at negedge, check in_ready, update model at edge, check outputs.
    task automatic step(input bit v, input logic [7:0] d, input bit b, input bit r,
                        input bit rr, input bit e, input bit c, input string tag);
        in_valid = v; in_data = d; brk_evt = b; rd_stb = r;
        rx_reset = rr; rx_en = e; brk_clr = c;
        #1;
        chk("R5", tag, {7'd0, in_ready}, {7'd0, exp_ready(e, b)});
        @(posedge clk);
        model_edge(v, d, b, r, rr, e, c);
        @(negedge clk);
        chk("R2", tag, rd_data, m_rd);
        chk("R3", tag, {7'd0, rdy_flag}, {7'd0, mcnt != 0});
        chk("R4", tag, {7'd0, full_flag}, {7'd0, mcnt == 4});
        chk("R8", tag, {7'd0, brk_flag}, {7'd0, m_brk});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset rdy", {7'd0, rdy_flag}, 8'h00);
        chk("R1", "reset full", {7'd0, full_flag}, 8'h00);
        chk("R1", "reset brk", {7'd0, brk_flag}, 8'h00);
        chk("R1", "reset data", rd_data, 8'h00);

        // R2, R6: push, read it back, then read while empty
        step(1, 8'hA5, 0, 0, 0, 1, 0, "R2 push");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R2 read");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R6 empty read");

        // R4, R5: fill to four, then an offered byte is refused
        step(1, 8'h11, 0, 0, 0, 1, 0, "R4 fill");
        step(1, 8'h22, 0, 0, 0, 1, 0, "R4 fill");
        step(1, 8'h33, 0, 0, 0, 1, 0, "R4 fill");
        step(1, 8'h44, 0, 0, 0, 1, 0, "R4 fill");
        step(1, 8'h55, 0, 0, 0, 1, 0, "R5 refused when full");
        // R7: break on full queue overwrites newest (0x44)
        step(0, 8'h00, 1, 0, 0, 1, 0, "R7 overwrite");
        // R10: break with a read on full queue appends after the pop
        step(0, 8'h00, 1, 1, 0, 1, 0, "R10 read+break");
        for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 1, 0, 1, 0, "R7 drain");

        // R5: disabled receiver ignores bytes; R7: break still taken
        step(1, 8'h66, 0, 0, 0, 0, 0, "R5 disabled");
        step(0, 8'h00, 1, 0, 0, 0, 0, "R7 break disabled");
        step(0, 8'h00, 0, 1, 0, 0, 0, "R7 read break byte");

        // R8: flag held, set wins over clear, then clear
        step(0, 8'h00, 0, 0, 0, 1, 0, "R8 hold");
        step(0, 8'h00, 1, 0, 0, 1, 1, "R8 set wins");
        step(0, 8'h00, 0, 0, 0, 1, 1, "R8 clear");

        // R9: reset overrides a same-cycle push and read
        step(1, 8'h77, 0, 0, 0, 1, 0, "R9 prefill");
        step(1, 8'h88, 0, 0, 0, 1, 0, "R9 prefill");
        step(1, 8'h99, 0, 1, 1, 1, 0, "R9 reset");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R9 read after reset");

        // R10: read and push together at one entry
        step(1, 8'hB1, 0, 0, 0, 1, 0, "R10 setup");
        step(1, 8'hB2, 0, 1, 0, 1, 0, "R10 read+push");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R10 read back");

        // Random mix (R2, R3, R4, R5, R7, R10)
        for (int n = 0; n < 4000; n++) begin
            bit v, b, r, rr, e, c;
            v  = ($urandom % 100) < 60;
            b  = ($urandom % 100) < 6;
            r  = ($urandom % 100) < 40;
            rr = ($urandom % 100) < 2;
            e  = ($urandom % 100) < 85;
            c  = ($urandom % 100) < 10;
            step(v, 8'($urandom), b, r, rr, e, c, "R10 random");
        end
        finish_run();
    end
endmodule